// File: doc/BRIEF.md
# Capture-and-Hold Status Register with Read Clearing

This block presents a row of status flags to a processor through a simple read strobe. A per-bit mode mask selects how each flag behaves. A live bit passes its status input straight through to the read data with no clock in the path. A latching bit is set when the capture strobe goes from low to high while that bit's input is high. The bit then stays set until the processor reads the register.

A read returns the value that was held before the read. The clear takes effect at the clock edge that ends the read cycle. A capture edge that arrives in the same cycle as the read is kept, so no event is lost. A read that comes before a capture edge sees the old contents, which can be zero. The register has its own read strobe, so reading it clears nothing in any other status register. The capture strobe is sampled on the system clock, and only its rising transitions count as capture events.

Top module: `evt_status_reg`

## Requirements
- R1: While reset is low, every latching bit holds 0. A latching bit therefore reads 0 during reset and after reset until a capture sets it.
- R2: For a bit whose mode-mask bit is 0 (live), `rd_data` equals `sts_in` in the same cycle, with no clock edge in between.
- R3: For a bit whose mode-mask bit is 1 (latching), the bit becomes 1 at a clock edge where `cap_en` is 1, `cap_en` was 0 at the previous edge, and its `sts_in` bit is 1.
- R4: While `cap_en` stays high over several edges, only the first edge counts as a capture. Inputs that rise later set nothing.
- R5: In a cycle where `rd_en` is 1, `rd_data` carries the held latching bits from before the read. Those bits are 0 from the next clock edge on.
- R6: When a capture event and a read fall in the same cycle, a bit that the capture sets is 1 after that edge. The bits that are not set are cleared.
- R7: A latching bit whose input is 0 at a capture edge keeps its held value.
- R8: The stored bit of a live bit is held at 0. If that bit is later switched to latching, it reads 0 until a capture sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_in | input | WIDTH | Live status inputs |
| mode_sticky | input | WIDTH | Per-bit mode: 1 = latching, 0 = live |
| cap_en | input | 1 | Capture strobe; its rising transition is the capture event |
| rd_en | input | 1 | Read strobe; clears held latching bits at the end of the cycle |
| rd_data | output | WIDTH | Read data: held bits for latching positions, live inputs otherwise |

## Verification
Two functions can meet in one cycle: a capture event that sets bits and a read that clears them. The bench provokes this by raising `cap_en` from low in the same cycle as `rd_en`. It does this once where the set bits differ from the held bits and once where they are the same bit. It then judges the next read: newly set bits must remain, and every other held bit must be gone. The read data in the colliding cycle must still show the pre-clear contents.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

  function automatic logic [63:0] next_hold(
    input logic [63:0] hold,
    input logic [63:0] set_bits,
    input logic [63:0] clr_bits,
    input logic [63:0] keep_mask
  );
    return ((hold & ~clr_bits) | set_bits) & keep_mask;
  endfunction

  function automatic logic [63:0] merge_read(
    input logic [63:0] held,
    input logic [63:0] live,
    input logic [63:0] sticky_mask
  );
    return (held & sticky_mask) | (live & ~sticky_mask);
  endfunction

endpackage

// File: rtl/evt_cap_edge.sv
module evt_cap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/evt_hold_bits.sv
module evt_hold_bits #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_v,
  input  logic [WIDTH-1:0] clr_v,
  input  logic [WIDTH-1:0] keep_v,
  output logic [WIDTH-1:0] hold_v
);
  import evt_status_pkg::*;

  logic [63:0] nxt_wide;
  assign nxt_wide = next_hold(64'(hold_v), 64'(set_v), 64'(clr_v), 64'(keep_v));

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_v[i] <= 1'b0;
      else        hold_v[i] <= nxt_wide[i];
    end
  end
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] held,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] sticky_mask,
  output logic [WIDTH-1:0] dout
);
  import evt_status_pkg::*;

  logic [63:0] mix_wide;
  assign mix_wide = merge_read(64'(held), 64'(live), 64'(sticky_mask));
  assign dout     = mix_wide[WIDTH-1:0];
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sts_in,
  input  logic [WIDTH-1:0] mode_sticky,
  input  logic             cap_en,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data
);
  logic             cap_rise_w;
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] clr_v;
  logic [WIDTH-1:0] hold_v;

  evt_cap_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_en),
    .rise   (cap_rise_w)
  );

  assign set_v = {WIDTH{cap_rise_w}} & sts_in & mode_sticky;
  assign clr_v = {WIDTH{rd_en}} & mode_sticky;

  evt_hold_bits #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .keep_v (mode_sticky),
    .hold_v (hold_v)
  );

  evt_read_mux #(.WIDTH(WIDTH)) u_mux (
    .held        (hold_v),
    .live        (sts_in),
    .sticky_mask (mode_sticky),
    .dout        (rd_data)
  );
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] sts_in,
  input logic [WIDTH-1:0] mode_sticky,
  input logic             cap_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             cap_rise_w,
  input logic [WIDTH-1:0] set_v,
  input logic [WIDTH-1:0] hold_v
);
  // R1
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |-> hold_v == '0);

  // R2
  a_r2_live_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data ^ sts_in) & ~mode_sticky) == '0);

  // R3
  a_r3_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((hold_v & $past(set_v)) == $past(set_v)));

  // R4
  a_r4_level_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise_w |=> ((hold_v & ~$past(hold_v)) == '0));

  // R5 with R6: after a read, only bits set in that cycle remain
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((hold_v & ~$past(set_v)) == '0));

  // R7
  a_r7_low_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((hold_v & $past(hold_v & mode_sticky)) == $past(hold_v & mode_sticky)));

  // R8
  a_r8_live_empty: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hold_v & ~$past(mode_sticky)) == '0));
endmodule

bind evt_status_reg evt_status_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sts_in      (sts_in),
  .mode_sticky (mode_sticky),
  .cap_en      (cap_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .cap_rise_w  (cap_rise_w),
  .set_v       (set_v),
  .hold_v      (hold_v)
);

// File: tb/sim_evt_status_reg.sv
module sim_evt_status_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] sts_in = '0;
  logic [W-1:0] mode_sticky = '0;
  logic         cap_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_status_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sts_in(sts_in), .mode_sticky(mode_sticky),
    .cap_en(cap_en), .rd_en(rd_en), .rd_data(rd_data)
  );

  // {sts, cap, rd, expected rd_data}; mode mask fixed at 8'h0F
  typedef struct packed {
    logic [7:0] sts;
    logic       cap;
    logic       rd;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{8'hA5, 1'b0, 1'b0, 8'hA0},  // R2 live high nibble
    '{8'hA5, 1'b1, 1'b0, 8'hA0},  // R3 capture edge
    '{8'h5A, 1'b1, 1'b0, 8'h55},  // R4 level held, no new set
    '{8'h00, 1'b0, 1'b1, 8'h05},  // R5 read shows old value
    '{8'h00, 1'b0, 1'b1, 8'h00},  // R5 cleared
    '{8'h03, 1'b1, 1'b0, 8'h00},  // R3 capture before visible
    '{8'h0C, 1'b0, 1'b0, 8'h03},  // R3 now held
    '{8'h0C, 1'b1, 1'b1, 8'h03},  // R6 set and clear together
    '{8'hFF, 1'b1, 1'b0, 8'hFC},  // R6 set kept, others cleared
    '{8'h00, 1'b0, 1'b0, 8'h0C},  // R7 hold steady
    '{8'h01, 1'b1, 1'b0, 8'h0C},  // R7 low inputs keep value
    '{8'hF0, 1'b0, 1'b1, 8'hFD},  // R7 merged hold
    '{8'h00, 1'b0, 1'b0, 8'h00}   // R5 empty after read
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] s, input logic [W-1:0] m, input logic c, input logic r);
    @(negedge clk);
    sts_in = s; mode_sticky = m; cap_en = c; rd_en = r;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: timeout expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: in reset, latching bits read 0 while live bits pass
    drive(8'hFF, 8'h0F, 1'b1, 1'b0);
    @(negedge clk); #1;
    check("R1 reset", rd_data, 8'hF0);
    drive(8'h00, 8'h0F, 1'b0, 1'b0);
    rst_n = 1'b1;
    check("R1 after reset", rd_data, 8'h00);

    for (int i = 0; i < 13; i++) begin
      drive(W'(VECS[i].sts), 8'h0F, VECS[i].cap, VECS[i].rd);
      check($sformatf("vector %0d", i), rd_data, W'(VECS[i].exp));
    end

    // R6: same bit already held, capture and read together
    drive(8'h01, 8'h0F, 1'b1, 1'b0);
    drive(8'h01, 8'h0F, 1'b0, 1'b0);
    drive(8'h01, 8'h0F, 1'b1, 1'b1);
    check("R6 same-bit collide read", rd_data, 8'h01);
    drive(8'h00, 8'h0F, 1'b0, 1'b0);
    check("R6 same-bit survives", rd_data, 8'h01);
    drive(8'h00, 8'h0F, 1'b0, 1'b1);
    drive(8'h00, 8'h0F, 1'b0, 1'b0);
    check("R5 clean", rd_data, 8'h00);

    // R8: held bit, switch to live, then back to latching
    drive(8'h80, 8'h80, 1'b1, 1'b0);
    drive(8'h00, 8'h80, 1'b0, 1'b0);
    check("R3 bit7 held", rd_data, 8'h80);
    drive(8'h00, 8'h00, 1'b0, 1'b0);
    check("R2 bit7 live", rd_data, 8'h00);
    drive(8'h00, 8'h80, 1'b0, 1'b0);
    check("R8 back to latching reads 0", rd_data, 8'h00);

    // R1: reset clears held bits
    drive(8'h0F, 8'h0F, 1'b1, 1'b0);
    drive(8'h00, 8'h0F, 1'b0, 1'b0);
    check("R3 pre-reset held", rd_data, 8'h0F);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00, 8'h0F, 1'b0, 1'b0);
    check("R1 stays clear", rd_data, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule